// File: doc/BRIEF.md
# Operand Effective Address Generator

This block resolves where the operand of one instruction lives and delivers either that operand or, for a store, the final address. A request carries a 3-bit addressing-mode code, a constant field taken from the instruction word, a base register value, an index register value and a 2-bit element-size code. The block raises `start` for one cycle. It then issues up to two single-cycle reads on a memory read port, and pulses `done` for one cycle together with the result.

Some modes step a pointer register automatically. In those modes the block also returns the updated base value with a write-enable, so the register file can write it back in the same cycle that `done` is high. Illegal requests do not stall. They finish with `done` and `error` high, and have no memory traffic and no write-back. Decoding, the register file, the ALU and branch targets belong to other blocks.

Top module: `operand_ea_gen`

## Requirements
- R1: While reset is active and in the first cycle after it, `done`, `mem_rd_req` and `base_wr_en` are low.
- R2: Mode code 0 (immediate) as a source returns the constant field zero-extended to 32 bits one cycle after `start`, with no memory read.
- R3: Mode 0 requested as a destination, and mode code 7 (reserved), finish one cycle after `start` with `done` and `error` high, no memory read and `base_wr_en` low.
- R4: Mode code 1 (register) returns the base register value one cycle after `start`, with no memory read, for both source and destination.
- R5: Mode code 2 (direct) uses the zero-extended constant field as the address. A source reads that address and returns the read data three cycles after `start`. A destination returns the address one cycle after `start` without reading.
- R6: Mode code 3 (indirect) first reads the word at the zero-extended constant field, then uses that word as the address. A source makes a second read there and returns its data five cycles after `start`. A destination returns the fetched address three cycles after `start`, after one read.
- R7: Mode code 4 (post-increment) uses the base value as the address, and writes back base + d.
- R8: Mode code 5 (pre-decrement) uses base − d both as the address and as the written-back base value.
- R9: Mode code 6 (scaled) forms the address as the sign-extended constant field + base + index × d.
- R10: The element size d is 1, 2, 4 or 8 bytes for size codes 0, 1, 2 and 3.
- R11: `base_wr_en` is high only in the `done` cycle of modes 4 and 5, and never in any other mode.
- R12: `done` lasts one cycle. A `start` that is seen while a request is in flight, including during its `done` cycle, is ignored.
- R13: Each memory read request lasts exactly one cycle, and the read data is taken in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request (sampled only when idle) |
| mode | input | 3 | Addressing-mode code (0..7) |
| is_dest | input | 1 | 1 = operand is a destination (return address) |
| const_field | input | 16 | Constant field from the instruction |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| size_code | input | 2 | Element-size code (d = 1 << code) |
| mem_rd_req | output | 1 | Memory read request, one cycle |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| done | output | 1 | Result valid, one-cycle pulse |
| error | output | 1 | Illegal request, valid with done |
| result | output | 32 | Operand value or destination address |
| base_wr_en | output | 1 | Write-enable for the updated base register |
| base_wr_val | output | 32 | Updated base register value |

## Verification
The results come at fixed times after the `start` edge. Requests without memory finish after one cycle, and so do destinations in modes other than indirect. A single-read source finishes after three cycles, an indirect destination after three, and an indirect source after five. The bench counts falling edges from the `start` edge until `done` is seen, and compares that count with these figures. It also samples `result`, `error` and the write-back signals on that same falling edge. A monitor on the rising edge counts the read requests and records their addresses, so that the number of reads, their order and their addresses are checked along with the timing.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        AM_IMM   = 3'd0,
        AM_REG   = 3'd1,
        AM_DIR   = 3'd2,
        AM_IND   = 3'd3,
        AM_POSTI = 3'd4,
        AM_PRED  = 3'd5,
        AM_SCALE = 3'd6,
        AM_RSVD  = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } seq_e;

endpackage

// File: rtl/ea_size_dec.sv
module ea_size_dec #(
    parameter int AW = 32
) (
    input  logic [1:0]    size_code,
    input  logic [AW-1:0] index_val,
    output logic [AW-1:0] elem_bytes,
    output logic [AW-1:0] index_scaled
);
    // d is a power of two, so index * d is a shift by the size code
    always_comb begin
        elem_bytes   = AW'(1) << size_code;
        index_scaled = index_val << size_code;
    end

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  amode_e        mode,
    input  logic [CW-1:0] const_field,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] elem_bytes,
    input  logic [AW-1:0] index_scaled,
    output logic [AW-1:0] const_zx,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] base_next,
    output logic          base_upd,
    output logic          mem_mode,
    output logic          ind_mode,
    output logic          bad_mode
);
    logic [AW-1:0] const_sx;
    logic [AW-1:0] base_dec;
    logic [AW-1:0] base_inc;

    generate
        if (CW < AW) begin : g_ext
            assign const_zx = {{(AW-CW){1'b0}}, const_field};
            assign const_sx = {{(AW-CW){const_field[CW-1]}}, const_field};
        end else begin : g_trunc
            assign const_zx = const_field[AW-1:0];
            assign const_sx = const_field[AW-1:0];
        end
    endgenerate

    always_comb begin
        base_inc  = base_val + elem_bytes;
        base_dec  = base_val - elem_bytes;
        eff_addr  = '0;
        base_next = base_val;
        base_upd  = 1'b0;
        mem_mode  = 1'b0;
        ind_mode  = 1'b0;
        bad_mode  = 1'b0;
        unique case (mode)
            AM_IMM:   ;
            AM_REG:   ;
            AM_DIR: begin
                eff_addr = const_zx;
                mem_mode = 1'b1;
            end
            AM_IND: begin
                eff_addr = const_zx;
                mem_mode = 1'b1;
                ind_mode = 1'b1;
            end
            AM_POSTI: begin
                eff_addr  = base_val;
                base_next = base_inc;
                base_upd  = 1'b1;
                mem_mode  = 1'b1;
            end
            AM_PRED: begin
                eff_addr  = base_dec;
                base_next = base_dec;
                base_upd  = 1'b1;
                mem_mode  = 1'b1;
            end
            AM_SCALE: begin
                eff_addr = const_sx + base_val + index_scaled;
                mem_mode = 1'b1;
            end
            default: bad_mode = 1'b1;
        endcase
    end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  amode_e        mode,
    input  logic          is_dest,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] const_zx,
    input  logic [AW-1:0] eff_addr,
    input  logic [AW-1:0] base_next,
    input  logic          base_upd,
    input  logic          mem_mode,
    input  logic          ind_mode,
    input  logic          bad_mode,
    input  logic [AW-1:0] mem_rd_data,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] result,
    output logic          base_wr_en,
    output logic [AW-1:0] base_wr_val
);
    typedef struct packed {
        seq_e          seq;
        amode_e        mode;
        logic          dest;
        logic          ptr_pend;
        logic          wb;
        logic          err;
        logic [AW-1:0] addr;
        logic [AW-1:0] res;
        logic [AW-1:0] base_new;
    } ctl_s;

    ctl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.seq)
            ST_IDLE: begin
                if (start) begin
                    st_d.mode     = mode;
                    st_d.dest     = is_dest;
                    st_d.wb       = base_upd;
                    st_d.base_new = base_next;
                    st_d.err      = 1'b0;
                    st_d.ptr_pend = 1'b0;
                    st_d.res      = '0;
                    if (bad_mode || (mode == AM_IMM && is_dest)) begin
                        st_d.err = 1'b1;
                        st_d.wb  = 1'b0;
                        st_d.seq = ST_DONE;
                    end else if (!mem_mode) begin
                        st_d.res = (mode == AM_IMM) ? const_zx : base_val;
                        st_d.seq = ST_DONE;
                    end else if (is_dest && !ind_mode) begin
                        st_d.res = eff_addr;
                        st_d.seq = ST_DONE;
                    end else begin
                        st_d.addr     = eff_addr;
                        st_d.ptr_pend = ind_mode;
                        st_d.seq      = ST_REQ;
                    end
                end
            end
            ST_REQ: st_d.seq = ST_WAIT;
            ST_WAIT: begin
                if (st_q.ptr_pend) begin
                    st_d.ptr_pend = 1'b0;
                    if (st_q.dest) begin
                        st_d.res = mem_rd_data;
                        st_d.seq = ST_DONE;
                    end else begin
                        st_d.addr = mem_rd_data;
                        st_d.seq  = ST_REQ;
                    end
                end else begin
                    st_d.res = mem_rd_data;
                    st_d.seq = ST_DONE;
                end
            end
            default: st_d.seq = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done        = (st_q.seq == ST_DONE);
    assign error       = done && st_q.err;
    assign base_wr_en  = done && st_q.wb;
    assign base_wr_val = st_q.base_new;
    assign mem_rd_req  = (st_q.seq == ST_REQ);
    assign mem_rd_addr = st_q.addr;
    assign result      = st_q.res;

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R11
    wb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |-> (done && (st_q.mode == AM_POSTI || st_q.mode == AM_PRED)));

    // R3
    err_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !base_wr_en);

    // R4
    no_read_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (st_q.mode != AM_IMM && st_q.mode != AM_REG && st_q.mode != AM_RSVD));

    // R12
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seq != ST_IDLE) |=> $stable(st_q.mode));

endmodule

// File: rtl/operand_ea_gen.sv
module operand_ea_gen
    import ea_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic          is_dest,
    input  logic [CW-1:0] const_field,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  logic [1:0]    size_code,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [AW-1:0] mem_rd_data,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] result,
    output logic          base_wr_en,
    output logic [AW-1:0] base_wr_val
);
    amode_e        mode_e;
    logic [AW-1:0] elem_bytes;
    logic [AW-1:0] index_scaled;
    logic [AW-1:0] const_zx;
    logic [AW-1:0] eff_addr;
    logic [AW-1:0] base_next;
    logic          base_upd;
    logic          mem_mode;
    logic          ind_mode;
    logic          bad_mode;

    assign mode_e = amode_e'(mode);

    ea_size_dec #(.AW(AW)) u_size (
        .size_code    (size_code),
        .index_val    (index_val),
        .elem_bytes   (elem_bytes),
        .index_scaled (index_scaled)
    );

    ea_addr_calc #(.AW(AW), .CW(CW)) u_calc (
        .mode         (mode_e),
        .const_field  (const_field),
        .base_val     (base_val),
        .elem_bytes   (elem_bytes),
        .index_scaled (index_scaled),
        .const_zx     (const_zx),
        .eff_addr     (eff_addr),
        .base_next    (base_next),
        .base_upd     (base_upd),
        .mem_mode     (mem_mode),
        .ind_mode     (ind_mode),
        .bad_mode     (bad_mode)
    );

    ea_ctrl #(.AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode        (mode_e),
        .is_dest     (is_dest),
        .base_val    (base_val),
        .const_zx    (const_zx),
        .eff_addr    (eff_addr),
        .base_next   (base_next),
        .base_upd    (base_upd),
        .mem_mode    (mem_mode),
        .ind_mode    (ind_mode),
        .bad_mode    (bad_mode),
        .mem_rd_data (mem_rd_data),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .done        (done),
        .error       (error),
        .result      (result),
        .base_wr_en  (base_wr_en),
        .base_wr_val (base_wr_val)
    );

endmodule

// File: tb/operand_ea_gen_tb.sv
module operand_ea_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic        is_dest = 1'b0;
    logic [15:0] const_field = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic [1:0]  size_code = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        done, error, base_wr_en;
    logic [31:0] result, base_wr_val;

    int tests = 0;
    int fails = 0;

    int          reqs;
    logic [31:0] req_addr [2];
    int          lat;
    logic [31:0] g_res, g_wbval;
    logic        g_err, g_wb;

    always #(CLK_PERIOD/2) clk = ~clk;

    operand_ea_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_dest(is_dest),
        .const_field(const_field), .base_val(base_val), .index_val(index_val),
        .size_code(size_code), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .done(done), .error(error), .result(result),
        .base_wr_en(base_wr_en), .base_wr_val(base_wr_val)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    // memory model: data one cycle after request; request monitor
    always @(posedge clk) begin
        if (mem_rd_req) begin
            mem_rd_data <= memf(mem_rd_addr);
            if (reqs < 2) req_addr[reqs] <= mem_rd_addr;
            reqs <= reqs + 1;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] m, input logic dst, input logic [15:0] c,
                         input logic [31:0] b, input logic [31:0] x, input logic [1:0] sz,
                         input logic hold);
        @(negedge clk);
        mode = m; is_dest = dst; const_field = c; base_val = b; index_val = x; size_code = sz;
        reqs = 0;
        start = 1'b1;
        @(negedge clk);
        if (!hold) start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        g_res = result; g_err = error; g_wb = base_wr_en; g_wbval = base_wr_val;
        if (lat >= 20) check(1'b0, "watchdog: done never seen", 32'(lat), 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!done && !mem_rd_req && !base_wr_en, "R1 outputs in reset", {29'b0, done, mem_rd_req, base_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !mem_rd_req && !base_wr_en, "R1 outputs after reset", {29'b0, done, mem_rd_req, base_wr_en}, 0);
    endtask

    task automatic t_immediate();
        do_op(3'd0, 1'b0, 16'hBEEF, 32'h0, 32'h0, 2'd0, 1'b0);
        check(g_res == 32'h0000_BEEF && !g_err, "R2 imm value", g_res, 32'h0000_BEEF);
        check(lat == 1 && reqs == 0, "R2 imm timing/no read", 32'(lat*16 + reqs), 32'd16);
        do_op(3'd0, 1'b1, 16'h1234, 32'h0, 32'h0, 2'd0, 1'b0);
        check(g_err && !g_wb && lat == 1 && reqs == 0, "R3 imm as dest", {31'b0, g_err}, 1);
        do_op(3'd7, 1'b0, 16'h0040, 32'h100, 32'h0, 2'd2, 1'b0);
        check(g_err && !g_wb && lat == 1 && reqs == 0, "R3 reserved mode", {31'b0, g_err}, 1);
    endtask

    task automatic t_register();
        do_op(3'd1, 1'b0, 16'h0, 32'h1234_5678, 32'h0, 2'd0, 1'b0);
        check(g_res == 32'h1234_5678 && lat == 1 && reqs == 0 && !g_err, "R4 reg source", g_res, 32'h1234_5678);
        do_op(3'd1, 1'b1, 16'h0, 32'hCAFE_0001, 32'h0, 2'd1, 1'b0);
        check(g_res == 32'hCAFE_0001 && lat == 1 && reqs == 0 && !g_wb, "R4 reg dest", g_res, 32'hCAFE_0001);
    endtask

    task automatic t_direct();
        do_op(3'd2, 1'b0, 16'h0400, 32'hFFFF_0000, 32'h0, 2'd2, 1'b0);
        check(g_res == memf(32'h400), "R5 direct source data", g_res, memf(32'h400));
        check(lat == 3 && reqs == 1 && req_addr[0] == 32'h400, "R5 R13 direct one read at const", req_addr[0], 32'h400);
        do_op(3'd2, 1'b1, 16'hFFFF, 32'h0, 32'h0, 2'd2, 1'b0);
        check(g_res == 32'h0000_FFFF && lat == 1 && reqs == 0, "R5 direct dest address", g_res, 32'h0000_FFFF);
    endtask

    task automatic t_indirect();
        logic [31:0] p;
        p = memf(32'h20);
        do_op(3'd3, 1'b0, 16'h0020, 32'h0, 32'h0, 2'd2, 1'b0);
        check(g_res == memf(p), "R6 indirect source data", g_res, memf(p));
        check(lat == 5 && reqs == 2 && req_addr[0] == 32'h20 && req_addr[1] == p,
              "R6 R13 indirect read order", req_addr[1], p);
        do_op(3'd3, 1'b1, 16'h0020, 32'h0, 32'h0, 2'd2, 1'b0);
        check(g_res == p && lat == 3 && reqs == 1, "R6 indirect dest pointer", g_res, p);
    endtask

    task automatic t_postinc();
        for (int s = 0; s < 4; s++) begin
            logic [31:0] d;
            d = 32'd1 << s;
            do_op(3'd4, 1'b0, 16'h0, 32'h0000_1000, 32'h0, 2'(s), 1'b0);
            check(req_addr[0] == 32'h1000 && g_res == memf(32'h1000), "R7 post-inc address", req_addr[0], 32'h1000);
            check(g_wb && g_wbval == 32'h1000 + d, "R7 R10 post-inc writeback", g_wbval, 32'h1000 + d);
        end
    endtask

    task automatic t_predec();
        do_op(3'd5, 1'b0, 16'h0, 32'h0000_2000, 32'h0, 2'd3, 1'b0);
        check(req_addr[0] == 32'h1FF8 && g_res == memf(32'h1FF8), "R8 pre-dec address", req_addr[0], 32'h1FF8);
        check(g_wb && g_wbval == 32'h1FF8, "R8 R11 pre-dec writeback", g_wbval, 32'h1FF8);
        do_op(3'd5, 1'b1, 16'h0, 32'h0000_0001, 32'h0, 2'd1, 1'b0);
        check(g_res == 32'hFFFF_FFFF && g_wbval == 32'hFFFF_FFFF && lat == 1 && reqs == 0,
              "R8 R10 pre-dec dest wrap", g_res, 32'hFFFF_FFFF);
    endtask

    task automatic t_scaled();
        do_op(3'd6, 1'b0, 16'hFFF0, 32'h0000_2000, 32'd3, 2'd2, 1'b0);
        check(req_addr[0] == 32'h1FFC && g_res == memf(32'h1FFC), "R9 scaled negative disp", req_addr[0], 32'h1FFC);
        check(!g_wb, "R11 scaled no writeback", {31'b0, g_wb}, 0);
        do_op(3'd6, 1'b1, 16'h0010, 32'h0000_0100, 32'd5, 2'd3, 1'b0);
        check(g_res == 32'h0000_0138 && lat == 1 && reqs == 0, "R9 R10 scaled dest", g_res, 32'h138);
    endtask

    task automatic t_busy();
        int extra;
        do_op(3'd2, 1'b0, 16'h0300, 32'h0, 32'h0, 2'd0, 1'b1);
        check(g_res == memf(32'h300) && lat == 3 && reqs == 1, "R12 held start one op", g_res, memf(32'h300));
        @(negedge clk);
        check(!done, "R12 done one cycle", {31'b0, done}, 0);
        extra = 0;
        for (int i = 0; i < 5; i++) begin
            if (done || mem_rd_req) extra++;
            @(negedge clk);
        end
        check(extra == 0, "R12 start during busy ignored", 32'(extra), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        reqs = 0;
        t_reset();
        t_immediate();
        t_register();
        t_direct();
        t_indirect();
        t_postinc();
        t_predec();
        t_scaled();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule